// File: doc/BRIEF.md
# Collective Write Data Striper

This block takes one sequential burst of data words coming back from a memory-side transfer and spreads it over a group of local SRAM banks. The banks together form one logical buffer. Each transfer starts with a descriptor that gives a starting local offset, a word count and a layout mode.

In concatenated layout the burst fills the logical buffer linearly: a bank is used through its full depth before the next bank starts. In interleaved layout, consecutive words go to consecutive banks in round-robin order at a shared row. The row advances once every bank has taken one word. This places row-major data so that each bank ends up holding one column slice.

Words arrive on a valid/ready stream and are written one per handshake through per-bank write ports. The banks are modelled as plain arrays, and each bank has a combinational read port for the consuming logic. A single-cycle completion pulse marks the end of each transfer.

Top module: `coll_stripe_top`

## Requirements
- R1: A descriptor is taken on a cycle where `desc_valid` and `desc_ready` are both high. `desc_ready` is high exactly while no transfer is active. A descriptor offered during an active transfer does not change that transfer's length, mode or placement.
- R2: `in_ready` is low while no transfer is active. Words offered then are not consumed and cause no bank write.
- R3: With `desc_mode` = 0 (concatenated), word k goes to bank (offset + k) / DEPTH at row (offset + k) mod DEPTH.
- R4: With `desc_mode` = 1 (interleaved), word k goes to bank k mod NBANK at row offset + k / NBANK.
- R5: Each accepted in-range word produces exactly one bank write, in the cycle of its handshake, carrying that word's data. At most one bit of `bank_we` is high in any cycle, and only when `in_valid` and `in_ready` are both high.
- R6: `done` is high for exactly one cycle: the cycle after the handshake of the final word. It is low at all other times during a transfer.
- R7: A descriptor with length 0 raises `done` in the cycle after it is taken, makes no bank write, and leaves the block idle.
- R8: A word whose target bank index is NBANK or more, or whose row is DEPTH or more, is still accepted and counted, but it writes no bank.
- R9: The word index advances only on a handshake. Cycles with `in_valid` low write nothing and skip no placement.
- R10: After reset, `desc_ready` is 1, `in_ready` is 0, `done` is 0 and `bank_we` is 0.
- R11: Bank b's read port returns, combinationally, the last word written to row `rd_addr` slice b of that bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| desc_valid | input | 1 | Descriptor offered |
| desc_ready | output | 1 | Block idle, descriptor can be taken |
| desc_offset | input | LAW | Starting local offset |
| desc_len | input | LENW | Word count of the transfer |
| desc_mode | input | 1 | 0 concatenated, 1 interleaved |
| in_valid | input | 1 | Incoming word valid |
| in_ready | output | 1 | Block accepts a word |
| in_data | input | DW | Incoming word |
| bank_we | output | NBANK | Per-bank write enable |
| bank_addr | output | NBANK*BAW | Per-bank write row, bank b at slice b |
| bank_wdata | output | NBANK*DW | Per-bank write data, bank b at slice b |
| rd_addr | input | NBANK*BAW | Per-bank read row |
| rd_data | output | NBANK*DW | Per-bank read data |
| done | output | 1 | One-cycle transfer completion pulse |

## Verification
The steering outputs (`bank_we`, `bank_addr`, `bank_wdata`) are combinational from the registered word index. The bench therefore checks them in the same cycle a word is offered, a moment after the falling edge and before the rising edge that completes the handshake. The array contents update on that rising edge. They are read back through the read ports only after the transfer ends, and compared against a model that marks which rows the bench has written. `done` comes from a register: it is sampled at the falling edge one cycle after the final handshake (or after the zero-length descriptor is taken), and again one cycle later, when it must be low.

// File: rtl/stripe_pkg.sv
package stripe_pkg;

  typedef enum logic {
    LAYOUT_CONCAT = 1'b0,
    LAYOUT_ILV    = 1'b1
  } layout_e;

  // Target bank of word k.
  function automatic int unsigned tgt_bank(layout_e lay, int unsigned off,
                                           int unsigned k, int unsigned nb,
                                           int unsigned dp);
    if (lay == LAYOUT_CONCAT) return (off + k) / dp;
    return k % nb;
  endfunction

  // Target row of word k.
  function automatic int unsigned tgt_row(layout_e lay, int unsigned off,
                                          int unsigned k, int unsigned nb,
                                          int unsigned dp);
    if (lay == LAYOUT_CONCAT) return (off + k) % dp;
    return off + (k / nb);
  endfunction

endpackage

// File: rtl/stripe_ctrl.sv
module stripe_ctrl
  import stripe_pkg::*;
#(
  parameter int LAW  = 6,
  parameter int LENW = 7
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            desc_valid,
  input  logic [LAW-1:0]  desc_offset,
  input  logic [LENW-1:0] desc_len,
  input  logic            desc_mode,
  input  logic            in_valid,
  output logic            desc_ready,
  output logic            in_ready,
  output logic            accept,
  output logic            fire,
  output logic            last_fire,
  output logic            zero_acc,
  output logic [LAW-1:0]  off_q,
  output logic [LENW-1:0] k_q,
  output layout_e         lay_q,
  output logic            done
);

  logic            busy_q;
  logic [LENW-1:0] len_q;
  logic            done_q;

  assign desc_ready = !busy_q;
  assign in_ready   = busy_q;
  assign accept     = desc_valid && !busy_q;
  assign zero_acc   = accept && (desc_len == '0);
  assign fire       = in_valid && busy_q;
  assign last_fire  = fire && (k_q == len_q - LENW'(1));
  assign done       = done_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      len_q  <= '0;
      k_q    <= '0;
      off_q  <= '0;
      lay_q  <= LAYOUT_CONCAT;
      done_q <= 1'b0;
    end else begin
      done_q <= last_fire || zero_acc;
      if (accept) begin
        busy_q <= (desc_len != '0);
        len_q  <= desc_len;
        off_q  <= desc_offset;
        lay_q  <= layout_e'(desc_mode);
        k_q    <= '0;
      end else if (fire) begin
        k_q <= k_q + LENW'(1);
        if (last_fire) busy_q <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/stripe_route.sv
module stripe_route
  import stripe_pkg::*;
#(
  parameter int NBANK = 4,
  parameter int DEPTH = 16,
  parameter int DW    = 16,
  parameter int LAW   = 6,
  parameter int LENW  = 7,
  parameter int BAW   = 4
) (
  input  logic                  fire,
  input  layout_e               lay,
  input  logic [LAW-1:0]        off,
  input  logic [LENW-1:0]       k,
  input  logic [DW-1:0]         wdata,
  output logic [NBANK-1:0]      we,
  output logic [NBANK*BAW-1:0]  addr,
  output logic [NBANK*DW-1:0]   data,
  output logic                  in_range
);

  int unsigned bank_i;
  logic [31:0] row_v;

  always_comb begin
    bank_i   = tgt_bank(lay, 32'(off), 32'(k), NBANK, DEPTH);
    row_v    = tgt_row(lay, 32'(off), 32'(k), NBANK, DEPTH);
    in_range = (bank_i < NBANK) && (row_v < DEPTH);
  end

  for (genvar b = 0; b < NBANK; b++) begin : g_port
    assign we[b] = fire && in_range && (bank_i == b);
    assign addr[b*BAW +: BAW] = row_v[BAW-1:0];
    assign data[b*DW +: DW]   = wdata;
  end

endmodule

// File: rtl/stripe_bank.sv
module stripe_bank #(
  parameter int DEPTH = 16,
  parameter int DW    = 16,
  parameter int BAW   = 4
) (
  input  logic           clk,
  input  logic           we,
  input  logic [BAW-1:0] waddr,
  input  logic [DW-1:0]  wdata,
  input  logic [BAW-1:0] raddr,
  output logic [DW-1:0]  rdata
);

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];

endmodule

// File: rtl/coll_stripe_top.sv
module coll_stripe_top
  import stripe_pkg::*;
#(
  parameter int NBANK = 4,
  parameter int DEPTH = 16,
  parameter int DW    = 16,
  localparam int BAW  = $clog2(DEPTH),
  localparam int LAW  = $clog2(NBANK * DEPTH),
  localparam int LENW = $clog2(NBANK * DEPTH + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 desc_valid,
  output logic                 desc_ready,
  input  logic [LAW-1:0]       desc_offset,
  input  logic [LENW-1:0]      desc_len,
  input  logic                 desc_mode,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [DW-1:0]        in_data,
  output logic [NBANK-1:0]     bank_we,
  output logic [NBANK*BAW-1:0] bank_addr,
  output logic [NBANK*DW-1:0]  bank_wdata,
  input  logic [NBANK*BAW-1:0] rd_addr,
  output logic [NBANK*DW-1:0]  rd_data,
  output logic                 done
);

  // Named internal events for the checker.
  logic            accept_w;
  logic            fire_w;
  logic            last_fire_w;
  logic            zero_acc_w;
  logic            in_range_w;
  logic [LAW-1:0]  off_w;
  logic [LENW-1:0] k_w;
  layout_e         lay_w;

  stripe_ctrl #(.LAW(LAW), .LENW(LENW)) ctrl_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .desc_valid (desc_valid),
    .desc_offset(desc_offset),
    .desc_len   (desc_len),
    .desc_mode  (desc_mode),
    .in_valid   (in_valid),
    .desc_ready (desc_ready),
    .in_ready   (in_ready),
    .accept     (accept_w),
    .fire       (fire_w),
    .last_fire  (last_fire_w),
    .zero_acc   (zero_acc_w),
    .off_q      (off_w),
    .k_q        (k_w),
    .lay_q      (lay_w),
    .done       (done)
  );

  stripe_route #(
    .NBANK(NBANK), .DEPTH(DEPTH), .DW(DW),
    .LAW(LAW), .LENW(LENW), .BAW(BAW)
  ) route_i (
    .fire    (fire_w),
    .lay     (lay_w),
    .off     (off_w),
    .k       (k_w),
    .wdata   (in_data),
    .we      (bank_we),
    .addr    (bank_addr),
    .data    (bank_wdata),
    .in_range(in_range_w)
  );

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    stripe_bank #(.DEPTH(DEPTH), .DW(DW), .BAW(BAW)) bank_i (
      .clk  (clk),
      .we   (bank_we[b]),
      .waddr(bank_addr[b*BAW +: BAW]),
      .wdata(bank_wdata[b*DW +: DW]),
      .raddr(rd_addr[b*BAW +: BAW]),
      .rdata(rd_data[b*DW +: DW])
    );
  end

endmodule

// File: rtl/stripe_chk.sv
module stripe_chk #(
  parameter int NBANK = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             desc_ready,
  input logic             in_valid,
  input logic             in_ready,
  input logic [NBANK-1:0] bank_we,
  input logic             done,
  input logic             last_fire,
  input logic             zero_acc
);

  // R5: never more than one bank written in a cycle
  p_we_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bank_we));

  // R5: a write only happens on a handshake
  p_we_on_fire_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (|bank_we) |-> (in_valid && in_ready));

  // R2: input stream is held off while idle
  p_hold_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    desc_ready |-> !in_ready);

  // R6: done lasts exactly one cycle
  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R6, R7: done follows a final handshake or an empty descriptor
  p_done_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (last_fire || zero_acc) |=> done);

  // R1: a busy block stays busy until its final word
  p_busy_holds_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!desc_ready && !last_fire) |=> !desc_ready);

endmodule

bind coll_stripe_top stripe_chk #(.NBANK(NBANK)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .desc_ready(desc_ready),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .bank_we   (bank_we),
  .done      (done),
  .last_fire (last_fire_w),
  .zero_acc  (zero_acc_w)
);

// File: tb/coll_stripe_tb.sv
module coll_stripe_top_tb_top;

  localparam int NB   = 4;
  localparam int DP   = 16;
  localparam int DW   = 16;
  localparam int BAW  = 4;
  localparam int LAW  = 6;
  localparam int LENW = 7;

  logic                clk = 1'b0;
  logic                rst_n = 1'b0;
  logic                desc_valid = 1'b0;
  logic                desc_ready;
  logic [LAW-1:0]      desc_offset = '0;
  logic [LENW-1:0]     desc_len = '0;
  logic                desc_mode = 1'b0;
  logic                in_valid = 1'b0;
  logic                in_ready;
  logic [DW-1:0]       in_data = '0;
  logic [NB-1:0]       bank_we;
  logic [NB*BAW-1:0]   bank_addr;
  logic [NB*DW-1:0]    bank_wdata;
  logic [NB*BAW-1:0]   rd_addr = '0;
  logic [NB*DW-1:0]    rd_data;
  logic                done;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  logic [DW-1:0] mdl [NB][DP];
  bit            known [NB][DP];

  always #2 clk = ~clk;

  coll_stripe_top #(.NBANK(NB), .DEPTH(DP), .DW(DW)) dut_i (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Bench-side placement: both layouts walked with counters.
  task automatic place(input int off, input int k, input int mode,
                       output int b, output int r);
    int lin;
    if (mode == 0) begin
      lin = off;
      for (int i = 0; i < k; i++) lin++;
      b = 0; r = lin;
      while (r >= DP) begin r -= DP; b++; end
    end else begin
      b = 0; r = off;
      for (int i = 0; i < k; i++) begin
        b++;
        if (b == NB) begin b = 0; r++; end
      end
    end
  endtask

  task automatic check_mem(input string req);
    for (int r = 0; r < DP; r++) begin
      for (int b = 0; b < NB; b++) rd_addr[b*BAW +: BAW] = BAW'(r);
      #1;
      for (int b = 0; b < NB; b++)
        if (known[b][r])
          chk(rd_data[b*DW +: DW] == mdl[b][r], req,
              int'(rd_data[b*DW +: DW]), int'(mdl[b][r]));
    end
  endtask

  task automatic run_xfer(input int off, input int len, input int mode,
                          input int gap, input bit intrude, input string req);
    int b, r;
    logic [NB-1:0] exp_we;
    logic [DW-1:0] w;
    @(negedge clk);
    chk(desc_ready == 1'b1, "R1 idle ready", int'(desc_ready), 1);
    desc_valid = 1'b1; desc_offset = LAW'(off);
    desc_len = LENW'(len); desc_mode = mode[0];
    @(posedge clk);
    @(negedge clk);
    desc_valid = 1'b0;
    if (len == 0) begin
      #1;
      chk(done == 1'b1, "R7 empty done", int'(done), 1);
      chk(bank_we == '0, "R7 no write", int'(bank_we), 0);
      chk(desc_ready == 1'b1, "R7 idle", int'(desc_ready), 1);
      @(negedge clk); #1;
      chk(done == 1'b0, "R7 pulse end", int'(done), 0);
      return;
    end
    for (int k = 0; k < len; k++) begin
      w = DW'(16'h5A00 + off * 37 + k * 11 + mode * 3);
      in_valid = 1'b1; in_data = w;
      if (intrude && k == 1) begin
        desc_valid = 1'b1; desc_offset = LAW'(0);
        desc_len = LENW'(2); desc_mode = ~mode[0];
      end
      #1;
      if (intrude && k == 1)
        chk(desc_ready == 1'b0, "R1 busy refuses", int'(desc_ready), 0);
      place(off, k, mode, b, r);
      exp_we = '0;
      if (b < NB && r < DP) exp_we[b] = 1'b1;
      chk(bank_we == exp_we, req, int'(bank_we), int'(exp_we));
      if (b < NB && r < DP) begin
        chk(bank_addr[b*BAW +: BAW] == BAW'(r), req,
            int'(bank_addr[b*BAW +: BAW]), r);
        chk(bank_wdata[b*DW +: DW] == w, "R5 data",
            int'(bank_wdata[b*DW +: DW]), int'(w));
        mdl[b][r] = w; known[b][r] = 1'b1;
      end
      if (done) chk(1'b0, "R6 early done", 1, 0);
      @(posedge clk);
      @(negedge clk);
      desc_valid = 1'b0;
      in_valid = 1'b0;
      if (k != len - 1) begin
        for (int g = 0; g < gap; g++) begin
          #1;
          chk(bank_we == '0, "R9 gap no write", int'(bank_we), 0);
          @(negedge clk);
        end
      end
    end
    #1;
    chk(done == 1'b1, "R6 done after last", int'(done), 1);
    chk(desc_ready == 1'b1, "R1 ready after last", int'(desc_ready), 1);
    @(negedge clk); #1;
    chk(done == 1'b0, "R6 single pulse", int'(done), 0);
    check_mem("R11 readback");
  endtask

  task automatic t_reset;
    @(negedge clk); #1;
    chk(desc_ready == 1'b1, "R10 desc_ready", int'(desc_ready), 1);
    chk(in_ready == 1'b0, "R10 in_ready", int'(in_ready), 0);
    chk(done == 1'b0, "R10 done", int'(done), 0);
    chk(bank_we == '0, "R10 bank_we", int'(bank_we), 0);
  endtask

  task automatic t_idle_push;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      in_valid = 1'b1; in_data = DW'(16'hDEAD);
      #1;
      chk(in_ready == 1'b0, "R2 held off", int'(in_ready), 0);
      chk(bank_we == '0, "R2 no write", int'(bank_we), 0);
    end
    @(negedge clk);
    in_valid = 1'b0;
    check_mem("R2 contents kept");
  endtask

  initial begin
    #(4 * 200000);
    if (!finished) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    for (int b = 0; b < NB; b++)
      for (int r = 0; r < DP; r++) known[b][r] = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    t_reset();
    run_xfer(0, 20, 0, 0, 1'b0, "R3 concat span");
    t_idle_push();
    run_xfer(2, 10, 1, 0, 1'b0, "R4 interleave");
    run_xfer(60, 8, 0, 0, 1'b0, "R8 concat overrun");
    run_xfer(14, 12, 1, 0, 1'b0, "R8 interleave overrun");
    run_xfer(5, 0, 0, 0, 1'b0, "R7 empty");
    run_xfer(30, 6, 0, 0, 1'b1, "R1 intrude concat");
    run_xfer(8, 9, 1, 2, 1'b0, "R9 gaps interleave");
    run_xfer(40, 5, 1, 1, 1'b1, "R4 intrude interleave");
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule